// File: doc/BRIEF.md
# Bus-Mastership Claim Sequencer

This block sits beside a client that sometimes needs to own a shared bus. That bus is governed by a request / grant / acknowledge handshake. When the client asks for the bus, the block raises a bus request and waits for a grant. It also watches the shared acknowledge line and waits until that line goes quiet, which means the previous owner has let go. Only then does it pull acknowledge itself to claim mastership, and it drops its request in the same cycle.

While it holds the bus, the block raises an ownership flag that the client uses to run its transfers. A single-cycle completion pulse from the client makes the block let go of acknowledge. It then passes through one release cycle and returns to idle.

The grant and the sampled acknowledge line come from outside the clock domain, so each passes through a synchroniser of SYNC_STAGES flops before the sequencer uses it. Acknowledge is modelled as an open-drain line. The block has a drive-enable output and reads the line back on a separate input. It never enables its driver while the line shows another owner.

Top module: `bus_claim_unit`

## Requirements
- R1: While reset is held, and just after it, bus_req_o, ack_oe_o and owned_o are all 0.
- R2: A client request seen at a clock edge while the unit is idle raises bus_req_o after that same edge.
- R3: With the shared acknowledge line idle, ack_oe_o rises SYNC_STAGES+2 edges after the first edge that samples grant_i high (4 edges with the default of 2 stages).
- R4: ack_oe_o stays 0 for as long as the synchronised acknowledge line shows another owner. If the other owner's acknowledge drops h cycles after grant rises, the claim happens max(SYNC_STAGES+2, h+SYNC_STAGES+1) edges after grant.
- R5: The claim raises ack_oe_o and lowers bus_req_o on the same edge.
- R6: owned_o is 1 exactly in the cycles where ack_oe_o is 1, and it is raised only after grant has been seen.
- R7: If grant drops before the claim, bus_req_o stays 1 and the unit waits for a fresh grant. Grant loss takes priority when it coincides with the acknowledge line going idle.
- R8: A one-cycle cli_done_i while owning clears ack_oe_o and owned_o on the next edge, with bus_req_o still 0. The unit is idle one edge later.
- R9: cli_req_i has no effect outside idle: while owning, bus_req_o stays 0. A request held through release starts a new request on the edge after the unit returns to idle.
- R10: cli_done_i has no effect when the unit does not own the bus: all three outputs stay 0 in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cli_req_i | input | 1 | Client asks for the bus (accepted in idle only) |
| cli_done_i | input | 1 | Client finished its transfers (one-cycle pulse) |
| grant_i | input | 1 | Grant from the bus arbiter, asynchronous |
| ack_line_i | input | 1 | Sampled level of the shared acknowledge line, asynchronous |
| bus_req_o | output | 1 | Bus request to the arbiter |
| ack_oe_o | output | 1 | Drive enable that pulls the shared acknowledge line active |
| owned_o | output | 1 | The client may run transfers on the bus |

## Verification
Losing the grant and seeing the acknowledge line go idle can arrive at the waiting state in the same cycle. Both inputs pass through synchronisers of equal depth. The bench therefore drops grant and the other owner's acknowledge on the same negative edge, so both changes reach the sequencer together. The expected outcome is no claim: the request stays high for many cycles, and the claim happens only SYNC_STAGES+2 edges after grant returns. A second coincidence is the client holding its request while it signals completion. The bench judges this by the exact edge on which the new request appears after release.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQUEST,
    ST_WAIT_ACK_IDLE,
    ST_MASTER,
    ST_RELEASE
  } bcu_state_e;

  // Request pin is high while asking and while waiting for the line to clear.
  function automatic logic state_drives_req(bcu_state_e s);
    return (s == ST_REQUEST) || (s == ST_WAIT_ACK_IDLE);
  endfunction

  // Acknowledge driver and ownership are only active when holding the bus.
  function automatic logic state_drives_ack(bcu_state_e s);
    return s == ST_MASTER;
  endfunction

  // Claim may happen only with grant present and the shared line idle.
  function automatic logic claim_allowed(logic grant_seen, logic ack_seen);
    return grant_seen && !ack_seen;
  endfunction

endpackage

// File: rtl/bcu_sync.sv
module bcu_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/bcu_fsm.sv
module bcu_fsm
  import bcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cli_req,
  input  logic       cli_done,
  input  logic       grant_seen,
  input  logic       ack_seen,
  output bcu_state_e state_q,
  output logic       ev_accept,
  output logic       ev_grant_lost,
  output logic       ev_claim,
  output logic       ev_release
);

  bcu_state_e state_d;

  always_comb begin
    state_d       = state_q;
    ev_accept     = 1'b0;
    ev_grant_lost = 1'b0;
    ev_claim      = 1'b0;
    ev_release    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cli_req) begin
          state_d   = ST_REQUEST;
          ev_accept = 1'b1;
        end
      end
      ST_REQUEST: begin
        if (grant_seen) state_d = ST_WAIT_ACK_IDLE;
      end
      ST_WAIT_ACK_IDLE: begin
        if (!grant_seen) begin
          state_d       = ST_REQUEST;
          ev_grant_lost = 1'b1;
        end else if (claim_allowed(grant_seen, ack_seen)) begin
          state_d  = ST_MASTER;
          ev_claim = 1'b1;
        end
      end
      ST_MASTER: begin
        if (cli_done) begin
          state_d    = ST_RELEASE;
          ev_release = 1'b1;
        end
      end
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/bus_claim_unit.sv
module bus_claim_unit
  import bcu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cli_req_i,
  input  logic cli_done_i,
  input  logic grant_i,
  input  logic ack_line_i,
  output logic bus_req_o,
  output logic ack_oe_o,
  output logic owned_o
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] synced;
  logic              grant_seen;
  logic              ack_seen;
  bcu_state_e        state_q;
  logic              in_idle;
  logic              ev_accept;
  logic              ev_grant_lost;
  logic              ev_claim;
  logic              ev_release;

  assign raw_in = {grant_i, ack_line_i};

  bcu_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (synced)
  );

  assign grant_seen = synced[1];
  assign ack_seen   = synced[0];

  bcu_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cli_req       (cli_req_i),
    .cli_done      (cli_done_i),
    .grant_seen    (grant_seen),
    .ack_seen      (ack_seen),
    .state_q       (state_q),
    .ev_accept     (ev_accept),
    .ev_grant_lost (ev_grant_lost),
    .ev_claim      (ev_claim),
    .ev_release    (ev_release)
  );

  assign in_idle   = (state_q == ST_IDLE);
  assign bus_req_o = state_drives_req(state_q);
  assign ack_oe_o  = state_drives_ack(state_q);
  assign owned_o   = (state_q == ST_MASTER);

endmodule

// File: rtl/bcu_checker.sv
module bcu_checker (
  input logic clk,
  input logic rst_n,
  input logic cli_req_i,
  input logic cli_done_i,
  input logic bus_req_o,
  input logic ack_oe_o,
  input logic owned_o,
  input logic grant_seen,
  input logic ack_seen,
  input logic in_idle,
  input logic ev_grant_lost,
  input logic ev_claim,
  input logic ev_release
);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cli_req_i) |=> bus_req_o);

  p_line_idle_before_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe_o) |-> !$past(ack_seen));

  p_claim_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe_o) |-> $fell(bus_req_o));

  p_owned_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owned_o) |-> $past(grant_seen));

  p_claim_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_claim |=> (ack_oe_o && owned_o));

  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant_lost |=> (bus_req_o && !ack_oe_o));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (owned_o && cli_done_i) |=> (ev_release == 1'b0 && !ack_oe_o && !owned_o && !bus_req_o));

  p_no_req_owning_r9: assert property (@(posedge clk) disable iff (!rst_n)
    owned_o |-> !bus_req_o);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cli_done_i && !cli_req_i) |=> !(bus_req_o || ack_oe_o || owned_o));

endmodule

bind bus_claim_unit bcu_checker u_bcu_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cli_req_i     (cli_req_i),
  .cli_done_i    (cli_done_i),
  .bus_req_o     (bus_req_o),
  .ack_oe_o      (ack_oe_o),
  .owned_o       (owned_o),
  .grant_seen    (grant_seen),
  .ack_seen      (ack_seen),
  .in_idle       (in_idle),
  .ev_grant_lost (ev_grant_lost),
  .ev_claim      (ev_claim),
  .ev_release    (ev_release)
);

// File: tb/bus_claim_unit_bench.sv
`timescale 1ns/1ps
module bus_claim_unit_bench;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cli_req = 1'b0;
  logic cli_done = 1'b0;
  logic grant = 1'b0;
  logic other_ack = 1'b0;
  logic bus_req, ack_oe, owned;
  logic ack_line;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  // Open-drain wired line: active when anyone pulls.
  assign ack_line = other_ack | ack_oe;

  bus_claim_unit #(.SYNC_STAGES(SYNC)) u_bus_claim_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .cli_req_i  (cli_req),
    .cli_done_i (cli_done),
    .grant_i    (grant),
    .ack_line_i (ack_line),
    .bus_req_o  (bus_req),
    .ack_oe_o   (ack_oe),
    .owned_o    (owned)
  );

  function automatic int claim_edges(int hold);
    int base = SYNC + 2;
    int late = hold + SYNC + 1;
    return (late > base) ? late : base;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_outs(string req, int r, int a, int o);
    chk(req, "bus_req", int'(bus_req), r);
    chk(req, "ack_oe",  int'(ack_oe),  a);
    chk(req, "owned",   int'(owned),   o);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  endtask

  // Release while the client may still hold its request; checks R8 timing.
  task automatic release_bus();
    cli_done = 1'b1;
    @(negedge clk);
    cli_done = 1'b0;
    chk_outs("R8", 0, 0, 0);
    @(negedge clk);
    chk_outs("R8", 0, 0, 0);
  endtask

  initial begin
    #40000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_outs("R1", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1", 0, 0, 0);

    // R10: completion pulse in idle changes nothing.
    cli_done = 1'b1;
    @(negedge clk);
    cli_done = 1'b0;
    chk_outs("R10", 0, 0, 0);
    @(negedge clk);
    chk_outs("R10", 0, 0, 0);

    // Sweep over how long the previous owner keeps acknowledge (R3, R4, R5, R6).
    for (int hold = 0; hold <= 6; hold++) begin
      other_ack = 1'b1;
      cli_req = 1'b1;
      @(negedge clk);
      cli_req = 1'b0;
      chk("R2", "bus_req after accept", int'(bus_req), 1);
      grant = 1'b1;
      if (hold == 0) other_ack = 1'b0;
      for (int t = 1; t <= claim_edges(hold); t++) begin
        @(negedge clk);
        if (t < claim_edges(hold)) begin
          chk("R4", "no claim while line busy", int'(ack_oe), 0);
          chk("R4", "request held", int'(bus_req), 1);
        end else begin
          chk("R3", "claim edge", int'(ack_oe), 1);
          chk("R5", "request drops at claim", int'(bus_req), 0);
          chk("R6", "owned with claim", int'(owned), 1);
        end
        if (t == hold) other_ack = 1'b0;
      end
      // R9: client request while owning has no effect.
      cli_req = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk_outs("R9", 0, 1, 1);
      end
      cli_req = 1'b0;
      grant = 1'b0;
      release_bus();
      repeat (SYNC + 2) @(negedge clk);
      chk_outs("R8", 0, 0, 0);
    end

    // R7: grant loss coinciding with the line going idle.
    other_ack = 1'b1;
    cli_req = 1'b1;
    grant = 1'b1;
    @(negedge clk);
    cli_req = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", "waiting on busy line", int'(ack_oe), 0);
    grant = 1'b0;
    other_ack = 1'b0;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      chk("R7", "no claim after grant loss", int'(ack_oe), 0);
      chk("R7", "request kept", int'(bus_req), 1);
    end
    grant = 1'b1;
    for (int t = 1; t <= SYNC + 2; t++) begin
      @(negedge clk);
      chk("R7", "claim on fresh grant", int'(ack_oe), (t == SYNC + 2) ? 1 : 0);
    end
    chk("R6", "owned equals drive", int'(owned), 1);

    // R9: request held through release restarts on the edge after idle.
    cli_req = 1'b1;
    grant = 1'b0;
    cli_done = 1'b1;
    @(negedge clk);
    cli_done = 1'b0;
    chk_outs("R8", 0, 0, 0);
    @(negedge clk);
    chk_outs("R9", 0, 0, 0);
    @(negedge clk);
    chk_outs("R9", 1, 0, 0);
    cli_req = 1'b0;
    repeat (4) @(negedge clk);
    chk_outs("R7", 1, 0, 0);

    report();
  end

endmodule